// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block puts a bank of general-purpose pins behind a simple word-addressed register bus. Each pin has a direction bit, and one data register holds the output value of the output pins and the sampled level of the input pins. A data access may land at any word offset inside the first 1 KiB of the block. The word-address bits then act as a per-pin mask, so software can read or change any subset of pins in one access, with no read-modify-write.

The data register follows each input pin through a two-flop synchroniser. Each output pin is driven from the data register. A pin set as an input is not driven by the block and reads as logic high on `pin_out`, which stands for the pull that a pad would provide. A small read-only area at the top of the 4 KiB space returns twelve identification bytes from a build-time constant, one byte in the low bits of each word. The bus is single-cycle: writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high, and read data is combinational from the address while `bus_sel` is high and `bus_wr` is low.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction register and the data register are both 0, so every bit of `pin_out` is 1.
- R2: A read at any byte offset 0x000–0x3FF returns the data register ANDed with mask = offset bits [9:2] in bits [7:0], and 0 in bits [31:8].
- R3: A write at any byte offset 0x000–0x3FF sets data bit i to `bus_wdata[i]` only where mask bit i (offset bit i+2) and direction bit i are both 1. Every other data bit keeps its value.
- R4: The direction register sits at byte offset 0x400 and can be read and written there. Bit i = 1 makes pin i an output.
- R5: For each pin, `pin_out[i]` equals data bit i when direction bit i is 1, and equals 1 when direction bit i is 0.
- R6: For a pin whose direction bit is 0, the data register copies `pin_in[i]` through a two-stage synchroniser. A level held on `pin_in` is readable from the data register after three rising edges.
- R7: A read at byte offset 0xFD0 + 4k, for k = 0..11, returns byte k of parameter `ID_VALUE` (bits [8k+7:8k]) in bits [7:0] and 0 in bits [31:8].
- R8: A read at any other offset (for example 0x404 or 0xFCC) returns 0. A write to such an offset changes neither the direction nor the data register.
- R9: Only `bus_wdata[7:0]` is used. Bits [31:8] have no effect on the direction or data register.
- R10: When no read is in progress (`bus_sel` low, or `bus_wr` high), `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Pin output levels, 1 where the pin is an input |

## Verification
The bench builds the block with its default parameters: 8 pins, a 12-bit address, a 32-bit data bus, two synchroniser stages and a 96-bit identification constant. With these values the whole address map can be reached: every one of the 256 mask patterns in the data window, the direction word, all twelve identification words and the gaps on either side of them. Random writes and pin changes put output and input pins side by side under partial masks. Directed cases cover an empty mask, a full mask, a write to a gap and stray upper write-data bits.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  // Number of identification bytes at the top of the map
  localparam int unsigned ID_BYTES = 12;

  // Which part of the map an address falls into
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_DATA = 2'd1,
    WIN_DIR  = 2'd2,
    WIN_ID   = 2'd3
  } win_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]           addr,
  output win_e                        win,
  output logic [NPINS-1:0]            mask,
  output logic [$clog2(ID_BYTES)-1:0] id_idx
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned IDX_W  = $clog2(ID_BYTES);
  localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1 << NPINS);
  localparam logic [WORD_W-1:0] ID_FIRST = WORD_W'((1 << WORD_W) - ID_BYTES);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] id_off;
  logic              unused_dec;

  assign word   = addr[ADDR_W-1:2];
  assign mask   = addr[NPINS+1:2];
  assign id_off = word - ID_FIRST;
  assign id_idx = id_off[IDX_W-1:0];

  always_comb begin
    win = WIN_NONE;
    if (addr[ADDR_W-1:NPINS+2] == '0) begin
      win = WIN_DATA;
    end else if (word == DIR_WORD) begin
      win = WIN_DIR;
    end else if (word >= ID_FIRST) begin
      win = WIN_ID;
    end
  end

  assign unused_dec = ^{addr[1:0], id_off[WORD_W-1:IDX_W]};

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_data_regs.sv
module gpio_data_regs #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data_en,
  input  logic             wr_dir_en,
  input  logic [NPINS-1:0] wr_mask,
  input  logic [NPINS-1:0] wr_val,
  input  logic [NPINS-1:0] pin_sync,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] data_q
);

  logic [NPINS-1:0] dir_d;
  logic [NPINS-1:0] data_d;
  logic [NPINS-1:0] upd;
  logic             dir_ld;

  // Next state
  always_comb begin
    dir_ld = wr_dir_en;
    dir_d  = wr_val;
    upd    = wr_data_en ? (wr_mask & dir_q) : '0;
    data_d = (data_q & dir_q & ~upd) | (wr_val & upd) | (pin_sync & ~dir_q);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      if (dir_ld) dir_q <= dir_d;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_mask_pkg::*;
#(
  parameter int unsigned          NPINS    = 8,
  parameter int unsigned          DATA_W   = 32,
  parameter logic [8*ID_BYTES-1:0] ID_VALUE = '0
) (
  input  logic                        rd_en,
  input  win_e                        win,
  input  logic [NPINS-1:0]            mask,
  input  logic [$clog2(ID_BYTES)-1:0] id_idx,
  input  logic [NPINS-1:0]            dir_q,
  input  logic [NPINS-1:0]            data_q,
  output logic [DATA_W-1:0]           rdata
);

  logic [7:0] id_tbl [ID_BYTES];

  for (genvar k = 0; k < ID_BYTES; k++) begin : g_id
    assign id_tbl[k] = ID_VALUE[8*k +: 8];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (win)
        WIN_DATA: rdata[NPINS-1:0] = data_q & mask;
        WIN_DIR:  rdata[NPINS-1:0] = dir_q;
        WIN_ID:   rdata[7:0]       = (32'(id_idx) < ID_BYTES) ? id_tbl[id_idx] : 8'h00;
        default:  rdata            = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned           NPINS       = 8,
  parameter int unsigned           ADDR_W      = 12,
  parameter int unsigned           DATA_W      = 32,
  parameter int unsigned           SYNC_STAGES = 2,
  parameter logic [8*ID_BYTES-1:0] ID_VALUE    = 96'h9E_24_C3_17_00_51_A8_06_00_00_00_00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out
);

  localparam int unsigned IDX_W = $clog2(ID_BYTES);

  win_e             win;
  logic [NPINS-1:0] mask;
  logic [IDX_W-1:0] id_idx;
  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] data_q;
  logic             wr_data_en;
  logic             wr_dir_en;
  logic             rd_en;
  logic             unused_wdata;

  gpio_addr_dec #(.NPINS(NPINS), .ADDR_W(ADDR_W)) dec_i (
    .addr   (bus_addr),
    .win    (win),
    .mask   (mask),
    .id_idx (id_idx)
  );

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_q)
  );

  assign wr_data_en = bus_sel && bus_wr && (win == WIN_DATA);
  assign wr_dir_en  = bus_sel && bus_wr && (win == WIN_DIR);
  assign rd_en      = bus_sel && !bus_wr;

  gpio_data_regs #(.NPINS(NPINS)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data_en (wr_data_en),
    .wr_dir_en  (wr_dir_en),
    .wr_mask    (mask),
    .wr_val     (bus_wdata[NPINS-1:0]),
    .pin_sync   (sync_q),
    .dir_q      (dir_q),
    .data_q     (data_q)
  );

  gpio_rd_mux #(.NPINS(NPINS), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) rd_i (
    .rd_en  (rd_en),
    .win    (win),
    .mask   (mask),
    .id_idx (id_idx),
    .dir_q  (dir_q),
    .data_q (data_q),
    .rdata  (bus_rdata)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pin_out[i] = dir_q[i] ? data_q[i] : 1'b1;
  end

  assign unused_wdata = ^bus_wdata[DATA_W-1:NPINS];

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  data_q,
  input logic [NPINS-1:0]  sync_q
);

  logic in_data_win;
  logic at_dir;
  logic is_gap;

  assign in_data_win = (bus_addr[ADDR_W-1:NPINS+2] == '0);
  assign at_dir      = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1 << NPINS));
  assign is_gap      = !in_data_win && !at_dir && (bus_addr < ADDR_W'((1 << ADDR_W) - 48));

  // R5: pins configured as inputs are seen high
  p_input_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out | dir_q) == '1));

  // R3: a data write leaves output bits outside the mask untouched
  p_masked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && in_data_win) |=>
      (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(bus_addr[NPINS+1:2])) == '0));

  // R6: input bits follow the synchroniser output one edge later
  p_input_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(sync_q)) & ~$past(dir_q)) == '0));

  // R8: direction changes only through a write at its own offset
  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && at_dir) |=> $stable(dir_q));

  // R8: gap offsets read as zero
  p_gap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && is_gap) |-> (bus_rdata == '0));

  // R10: no read in progress means zero read data
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |-> (bus_rdata == '0));

  // R2: read data never reaches above the pin bits in the data window
  p_rd_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && in_data_win) |-> (bus_rdata[DATA_W-1:NPINS] == '0));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
  .NPINS  (NPINS),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .dir_q     (dir_q),
  .data_q    (data_q),
  .sync_q    (sync_q)
);

// File: tb/gpio_mask_port_tb_top.sv
module gpio_mask_port_tb_top;

  localparam logic [95:0] TB_ID = 96'h9E_24_C3_17_00_51_A8_06_00_00_00_00;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;

  int unsigned n_checks;
  int unsigned n_fails;
  bit          done;

  logic [7:0] m_dir;
  logic [7:0] m_data;
  logic [7:0] m_pin;

  gpio_mask_port #(.ID_VALUE(TB_ID)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] exp_pins(input logic [7:0] d, input logic [7:0] dr);
    return (d & dr) | ~dr;
  endfunction

  function automatic logic [7:0] settle(input logic [7:0] d, input logic [7:0] dr,
                                        input logic [7:0] p);
    return (d & dr) | (p & ~dr);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic model_data_write(input logic [11:0] a, input logic [31:0] d);
    logic [7:0] upd;
    upd    = a[9:2] & m_dir;
    m_data = (m_data & ~upd) | (d[7:0] & upd);
    wr(a, d);
  endtask

  task automatic model_dir_write(input logic [31:0] d);
    m_data = settle(m_data, m_dir, m_pin);
    m_dir  = d[7:0];
    m_data = settle(m_data, m_dir, m_pin);
    wr(12'h400, d);
  endtask

  task automatic set_pins(input logic [7:0] p);
    @(negedge clk);
    pin_in = p;
    m_pin  = p;
    repeat (4) @(posedge clk);
    m_data = settle(m_data, m_dir, m_pin);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed_dummy;
    n_checks = 0; n_fails = 0; done = 1'b0;
    seed_dummy = $urandom(32'h5EED_0042);
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = 8'h00;
    m_dir = '0; m_data = '0; m_pin = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 pin_out", {24'h0, pin_out}, 32'h0000_00FF);
    rd_check("R1 dir", 12'h400, 32'h0);
    rd_check("R1 data", 12'h3FC, 32'h0);
    rst_n = 1'b1;

    // R10: idle bus gives zero
    @(negedge clk); #1;
    check("R10 idle", bus_rdata, 32'h0);

    // R6: inputs reach the data register after three edges
    @(negedge clk);
    pin_in = 8'hA5; m_pin = 8'hA5;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h3FC; #1;
    check("R6 not yet after two edges", bus_rdata, 32'h0);
    @(posedge clk); @(negedge clk); #1;
    check("R6 after three edges", bus_rdata, 32'h0000_00A5);
    bus_sel = 1'b0;
    m_data = settle(m_data, m_dir, m_pin);

    // R4, R9: direction with stray upper bits
    model_dir_write(32'hFFFF_FF0F);
    rd_check("R4 R9 dir readback", 12'h400, 32'h0000_000F);
    check("R5 pin_out after dir", {24'h0, pin_out}, {24'h0, exp_pins(m_data, m_dir)});

    // R3: write with full mask, only output bits change
    model_data_write(12'h3FC, 32'hDEAD_BE5A);
    rd_check("R3 full mask", 12'h3FC, {24'h0, m_data});
    // R2: empty mask reads zero
    rd_check("R2 empty mask", 12'h000, 32'h0);
    // R3: empty mask write changes nothing
    model_data_write(12'h000, 32'h0000_00FF);
    rd_check("R3 empty mask write", 12'h3FC, {24'h0, m_data});

    // R7: identification words
    for (int k = 0; k < 12; k++) begin
      rd_check("R7 id", 12'(12'hFD0 + 4*k), {24'h0, TB_ID[8*k +: 8]});
    end

    // R8: gaps read zero, writes ignored
    rd_check("R8 gap 0x404", 12'h404, 32'h0);
    rd_check("R8 gap 0xFCC", 12'hFCC, 32'h0);
    wr(12'h404, 32'hFFFF_FFFF);
    wr(12'hFCC, 32'hFFFF_FFFF);
    rd_check("R8 dir after gap write", 12'h400, {24'h0, m_dir});
    rd_check("R8 data after gap write", 12'h3FC, {24'h0, m_data});

    // Random mix: R2 R3 R4 R5 R6
    for (int it = 0; it < 400; it++) begin
      int unsigned op;
      logic [11:0] a;
      logic [31:0] d;
      op = $urandom_range(0, 4);
      a  = {2'b00, 8'($urandom), 2'($urandom)};
      d  = $urandom;
      case (op)
        0: begin
          model_data_write(a, d);
          check("R5 pin_out", {24'h0, pin_out}, {24'h0, exp_pins(m_data, m_dir)});
        end
        1: model_dir_write(d);
        2: rd_check("R2 masked read", a, {24'h0, m_data & a[9:2]});
        3: begin
          set_pins(8'($urandom));
          rd_check("R6 input sample", 12'h3FC, {24'h0, m_data});
        end
        default: rd_check("R4 dir read", 12'h400, {24'h0, m_dir});
      endcase
    end
    check("R5 final pin_out", {24'h0, pin_out}, {24'h0, exp_pins(m_data, m_dir)});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule